// File: doc/BRIEF.md
# Serial ADC Output Emulator

This block is a synthesizable stand-in for the output pins of a small 8-bit serial sampling converter. A capture front-end under test can talk to it in place of the real part. The host drives an active-low chip select and a serial clock. A parallel sample word stands for the analog level being converted. The emulator answers on a serial data pin that has a separate output enable, so the pin can be modelled as three-state at the pad.

Every input is sampled with the system clock, and edges of chip select and the serial clock are found from registered copies. When chip select goes low, the emulator captures the sample word and starts a frame. A frame has 12 bit slots: four zero slots come first, then the eight sample bits, most significant first. The emulator moves to the next slot only after a falling serial-clock edge, so the host reads each bit on the rising edge. After the last data bit the enable drops, which stands for high impedance, and `frame_done` pulses once. The sample code scale is 256 times the input voltage over a 3.3 V reference, so code 255 is full scale.

The sample word is a level input, not a stream. It has no valid or ready, because the converter samples it when a frame starts and cannot hold it off. The serial link has no back-pressure either: the host owns the clock and the block only follows it.

Top module: `adc_serial_emu`

## Requirements
- R1: While `cs_n` is high, and from reset, `sdo_oe`, `sdo` and `frame_done` are all 0.
- R2: One system clock after a falling edge of `cs_n`, `sdo_oe` is 1 and `sdo` is 0, which is bit slot 0. The sample word is captured in that same cycle.
- R3: Slots 0 to 3 carry 0. Slots 4 to 11 carry the captured word, bit 7 first and bit 0 last. `sdo_oe` stays 1 through all 12 slots.
- R4: `sdo` and `sdo_oe` change only in the system-clock cycle after a falling serial-clock edge or after an edge of `cs_n`. A rising serial-clock edge never moves them.
- R5: Changes on `sample` after the frame has started do not affect the bits sent in that frame.
- R6: One system clock after the falling serial-clock edge that ends slot 11, `sdo_oe` goes to 0 and `frame_done` is 1 for exactly one cycle.
- R7: Further serial-clock edges while `cs_n` is still low keep `sdo_oe` at 0 and raise no further `frame_done`.
- R8: If `cs_n` returns high in the middle of a frame, `sdo_oe` goes to 0 one clock later and no `frame_done` follows. The next falling edge of `cs_n` starts a complete new frame from slot 0.
- R9: If `cs_n` rises in the same clock cycle as the falling serial-clock edge that would end slot 11, the abort wins: no `frame_done` pulse and `sdo_oe` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every other input |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select from the host, active low; a falling edge starts a frame |
| sclk | input | 1 | Serial clock from the host |
| sample | input | 8 | Conversion code standing for the analog input |
| sdo | output | 1 | Serial data bit; only meaningful while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Drive enable for `sdo`; 0 stands for high impedance |
| frame_done | output | 1 | One-cycle pulse after the last data bit has been released |

## Verification
The end of a frame and the release of chip select can land in the same system-clock cycle: the falling serial-clock edge that closes slot 11 and `cs_n` going high. The bench provokes this by lowering the serial clock and raising chip select on the same clock. It judges the result by the absence of `frame_done` and by the enable dropping. It then checks that a following frame still arrives whole. A scoreboard compares every completed frame with the word that was queued when that frame started.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  // Which part of the frame the current bit slot belongs to
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_DATA = 2'd2
  } emu_phase_e;

endpackage

// File: rtl/emu_edge_det.sv
module emu_edge_det #(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= IDLE_LVL;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;
  assign fall = ~din & din_q;
endmodule

// File: rtl/emu_frame_ctrl.sv
module emu_frame_ctrl
  import adc_emu_pkg::*;
#(
  parameter int LEAD_BITS = 4,
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       cs_fall,
  input  logic       sclk_fall,
  output logic       active,
  output logic       step,
  output logic       done,
  output emu_phase_e phase
);
  localparam int FRAME_LEN = LEAD_BITS + DATA_BITS;
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(LEAD_BITS);

  logic [CNT_W-1:0] pos;

  assign step = sclk_fall & active & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cs_n) begin
        active <= 1'b0;
        pos    <= '0;
      end else if (cs_fall) begin
        active <= 1'b1;
        pos    <= '0;
      end else if (step) begin
        if (pos == LAST_POS) begin
          active <= 1'b0;
          pos    <= '0;
          done   <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!active)               phase = PH_IDLE;
    else if (pos < FIRST_DATA) phase = PH_LEAD;
    else                       phase = PH_DATA;
  end

  // R1 / R8: a high chip select idles the frame on the next clock
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !active);
  // R2: a chip-select fall opens slot 0
  a_r2_frame_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !cs_n) |=> (active && pos == '0));
  // R6: done is a single-cycle pulse with the line released
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);
  // R7: once released, only a new chip-select fall re-enables the line
  a_r7_stay_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cs_fall) |=> !active);
  // R9: a frame cut short by chip select never reports completion
  a_r9_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !done);
endmodule

// File: rtl/emu_shifter.sv
module emu_shifter
  import adc_emu_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 shift,
  input  emu_phase_e           phase,
  input  logic [DATA_BITS-1:0] sample,
  output logic                 sdo
);
  logic [DATA_BITS-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (load)  word <= sample;
    else if (shift) word <= {word[DATA_BITS-2:0], 1'b0};
  end

  assign sdo = (phase == PH_DATA) & word[DATA_BITS-1];

  // R5: the captured word only moves on load or on a data-slot shift
  a_r5_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(word));
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import adc_emu_pkg::*;
#(
  parameter int LEAD_BITS = 4,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic [DATA_BITS-1:0] sample,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic                 frame_done
);
  logic       cs_rise, cs_fall;
  logic       sclk_rise, sclk_fall;
  logic       active, step, done;
  emu_phase_e phase;

  emu_edge_det #(.IDLE_LVL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .rise(cs_rise), .fall(cs_fall)
  );

  emu_edge_det #(.IDLE_LVL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sclk_rise), .fall(sclk_fall)
  );

  emu_frame_ctrl #(.LEAD_BITS(LEAD_BITS), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall), .active(active), .step(step), .done(done),
    .phase(phase)
  );

  emu_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(cs_fall & ~cs_n),
    .shift(step && (phase == PH_DATA)), .phase(phase), .sample(sample),
    .sdo(sdo)
  );

  assign sdo_oe     = active;
  assign frame_done = done;

  // R4: without a falling serial edge or a chip-select edge the pin holds
  a_r4_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_fall && !cs_rise) |=> ($stable(sdo) && $stable(sdo_oe)));
  // R4: a rising serial edge alone never moves data
  a_r4_rise_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !cs_fall && !cs_rise) |=> $stable(sdo));
  // R1: chip select high keeps everything quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!sdo_oe && !sdo && !frame_done));
endmodule

// File: tb/adc_serial_emu_test.sv
module adc_serial_emu_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic [7:0] sample = 8'h00;
  logic       sdo, sdo_oe, frame_done;

  int checks = 0;
  int fails = 0;
  int done_seen = 0;
  bit r4_ok = 1'b1;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_serial_emu uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample),
    .sdo(sdo), .sdo_oe(sdo_oe), .frame_done(frame_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: captures bits on rising serial edges, scores on frame_done
  initial begin : monitor
    logic       prev_sclk;
    int         nbits;
    logic [11:0] cap;
    bit         oe_ok;
    logic [7:0] e;
    prev_sclk = 1'b0; nbits = 0; cap = '0; oe_ok = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (cs_n) begin
        nbits = 0;
        oe_ok = 1'b1;
      end else if (sclk && !prev_sclk) begin
        if (nbits < 12) begin
          cap = {cap[10:0], sdo};
          if (!sdo_oe) oe_ok = 1'b0;
          nbits++;
        end else begin
          check(!sdo_oe, "R7 enable after frame", sdo_oe, 0);
        end
      end
      if (frame_done) begin
        done_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected frame_done", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(nbits == 12 && oe_ok, "R3 slot count and enable", nbits, 12);
          check(cap[11:8] == 4'h0, "R2 leading zeros", cap[11:8], 0);
          check(cap[7:0] == e, "R3 data word MSB first", cap[7:0], e);
        end
      end
      prev_sclk = sclk;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame(input logic [7:0] s);
    @(negedge clk);
    sample = s;
    cs_n = 1'b0;
    tick(1);
    check(sdo_oe == 1'b1 && sdo == 1'b0, "R2 slot 0 after select", {sdo_oe, sdo}, 2);
    tick(1);
  endtask

  task automatic pulse_sclk(input int n);
    logic v0;
    repeat (n) begin
      sclk = 1'b1;
      v0 = sdo;
      tick(HALF_SCLK);
      if (sdo !== v0) r4_ok = 1'b0;
      sclk = 1'b0;
      tick(HALF_SCLK);
    end
  endtask

  task automatic full_frame(input logic [7:0] s, input bit mutate, input int extra);
    int d0;
    d0 = done_seen;
    r4_ok = 1'b1;
    exp_q.push_back(s);
    open_frame(s);
    if (mutate) sample = ~s;            // R5: must not reach the line
    pulse_sclk(11);
    if (mutate) sample = 8'h00;
    sclk = 1'b1;
    tick(HALF_SCLK);
    sclk = 1'b0;
    tick(1);
    check(sdo_oe == 1'b0 && frame_done == 1'b1, "R6 release with pulse", {sdo_oe, frame_done}, 1);
    tick(1);
    check(frame_done == 1'b0, "R6 pulse one cycle", frame_done, 0);
    check(r4_ok, "R4 data held while sclk high", r4_ok, 1);
    if (extra > 0) begin
      tick(1);
      pulse_sclk(extra);
      check(sdo_oe == 1'b0, "R7 stays released", sdo_oe, 0);
      check(done_seen == d0 + 1, "R7 no second frame_done", done_seen, d0 + 1);
    end
    cs_n = 1'b1;
    tick(3);
    check(done_seen == d0 + 1, "R6 one completion per frame", done_seen, d0 + 1);
    check(!sdo_oe && !sdo && !frame_done, "R1 idle between frames", {sdo_oe, sdo, frame_done}, 0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : driver
    int d0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check(!sdo_oe && !sdo && !frame_done, "R1 reset state", {sdo_oe, sdo, frame_done}, 0);

    full_frame(8'h00, 1'b0, 0);
    full_frame(8'hFF, 1'b0, 0);
    full_frame(8'hA5, 1'b0, 0);
    full_frame(8'h5A, 1'b0, 0);
    full_frame(8'h80, 1'b0, 0);
    full_frame(8'h01, 1'b0, 0);
    full_frame(8'h3C, 1'b1, 0);         // R5 sample changes mid-frame
    full_frame(8'hE7, 1'b0, 3);         // R7 extra clocks after last bit

    // R8: chip select released in the middle of the frame
    d0 = done_seen;
    open_frame(8'h77);
    pulse_sclk(5);
    cs_n = 1'b1;
    tick(1);
    check(sdo_oe == 1'b0, "R8 abort releases line", sdo_oe, 0);
    tick(3);
    check(done_seen == d0, "R8 abort gives no completion", done_seen, d0);
    full_frame(8'h96, 1'b0, 0);         // R8 restart is a whole frame

    // R9: chip select rises together with the closing serial fall
    d0 = done_seen;
    open_frame(8'h4B);
    pulse_sclk(11);
    sclk = 1'b1;
    tick(HALF_SCLK);
    sclk = 1'b0;
    cs_n = 1'b1;
    tick(1);
    check(!sdo_oe && !frame_done, "R9 abort wins over completion", {sdo_oe, frame_done}, 0);
    tick(3);
    check(done_seen == d0, "R9 no completion counted", done_seen, d0);
    full_frame(8'hC8, 1'b0, 0);

    check(exp_q.size() == 0, "R3 every queued word scored", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule